// File: doc/BRIEF.md
# Audio Sample-Rate Clock Generator

This block produces the frame clock (`lrclk`) and the bit clock (`bclk`) of a codec's serial audio port when the codec drives that port as clock master. It runs on the master clock `clk` and divides it by a ratio that an 8-bit control byte selects. The control byte holds a mode bit, a five-bit rate code and two halving bits. In standard mode the frame lasts a fixed multiple of the sample period (128, 192, 256 or 384 master clocks), and the frame always holds 32 bit clocks. In the 12/24 MHz mode the master clock is divided by integer ratios that only approximate the usual sample rates, with one bit clock every two master clocks. In that mode a frame can hold an odd number of bit clocks, so the frame clock is high for one bit clock longer than it is low.

The control byte is written through a synchronous write port. The generator runs with the new setting only from the next frame boundary, so no bit clock or frame clock period is ever cut short. A one-cycle `frame_strobe` marks each rising edge of `lrclk`. Pulling `enable` low stops the generator and drives both clocks low. Raising `enable` again starts a fresh frame.

Top module: `srg_clkgen`

## Requirements
- R1: After reset `lrclk`, `bclk` and `frame_strobe` are low, and the control byte reads as zero, which is standard mode with rate code 0 and both halving bits clear.
- R2: Control bit 0 is 0 for standard mode, and bits 5:1 hold the rate code. The frame length in `clk` cycles is 256 for code 0, 128 for code 1, 384 for code 2 and 192 for code 3. Any other code gives 256. Each frame holds 32 `bclk` periods of length/32 cycles.
- R3: When bit 6 is 1, `clk` is halved before any rate division, so the frame, high-time and `bclk` periods are twice as long.
- R4: When bit 0 is 1 (12/24 MHz mode), the frame length is 250 for code 0, 272 for code 17 (10001) and 1496 for code 6 (00110). Any other code gives 250. The `bclk` period is 2 cycles.
- R5: In 12/24 MHz mode with `enable` high, bit 7 set to 1 makes the `bclk` period 4 cycles. The frame then holds floor(ratio/4) `bclk` periods.
- R6: In standard mode bit 7 has no effect on any output.
- R7: `lrclk` is high for the first ceil(N/2) of the N `bclk` periods in a frame and low for the rest. For odd N the high time and the low time differ.
- R8: Each `bclk` period is low for its first half and high for its second half. `lrclk` changes only while `bclk` is low, and `bclk` is low at the start of each frame.
- R9: `frame_strobe` is high for exactly one `clk` cycle, in the cycle in which `lrclk` has just risen.
- R10: A write to the control byte does not change the frame in progress. It takes effect from the next frame boundary.
- R11: While `enable` is low, all three outputs are low one cycle later. After `enable` rises, a frame starts with `frame_strobe` within 3 cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Master clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Control byte write strobe |
| wr_data | input | 8 | Control byte value |
| enable | input | 1 | Run the generator as clock master |
| lrclk | output | 1 | Frame clock |
| bclk | output | 1 | Bit clock |
| frame_strobe | output | 1 | One-cycle pulse on each `lrclk` rise |

## Verification
The assertions assume that `clk` runs without gaps. They also assume that `wr_en` and `enable` change only between edges, because the frame-hold check ties the active setting to the frame boundaries alone. The bench drives every input on the falling edge and picks its random settings from the listed and unlisted rate codes, with both halving bits free. It changes `enable` only in a directed sequence, so each measured frame is one complete frame under a single setting.

// File: rtl/srg_pkg.sv
package srg_pkg;
  parameter int RATIO_W   = 11;
  parameter int BIT_W     = 10;
  parameter int HALF_W    = 4;
  parameter int NORM_BITS = 32;

  typedef struct packed {
    logic       bclk_half;
    logic       mclk_half;
    logic [4:0] rate;
    logic       usb;
  } ctl_t;

  function automatic logic [RATIO_W-1:0] norm_ratio(input logic [4:0] code);
    case (code)
      5'd1:    norm_ratio = RATIO_W'(128);
      5'd2:    norm_ratio = RATIO_W'(384);
      5'd3:    norm_ratio = RATIO_W'(192);
      default: norm_ratio = RATIO_W'(256);
    endcase
  endfunction

  function automatic logic [RATIO_W-1:0] usb_ratio(input logic [4:0] code);
    case (code)
      5'b10001: usb_ratio = RATIO_W'(272);
      5'b00110: usb_ratio = RATIO_W'(1496);
      default:  usb_ratio = RATIO_W'(250);
    endcase
  endfunction
endpackage

// File: rtl/srg_ctl_regs.sv
module srg_ctl_regs
  import srg_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       wr_en,
  input  logic [7:0] wr_data,
  input  logic       load,
  output ctl_t       act
);
  ctl_t pend_q, pend_d, act_q, act_d;

  always_comb begin
    pend_d = pend_q;
    act_d  = act_q;
    if (wr_en) pend_d = ctl_t'(wr_data);
    if (load)  act_d  = pend_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pend_q <= '0;
      act_q  <= '0;
    end else begin
      pend_q <= pend_d;
      act_q  <= act_d;
    end
  end

  assign act = act_q;
endmodule

// File: rtl/srg_rate_decode.sv
module srg_rate_decode
  import srg_pkg::*;
(
  input  ctl_t              act,
  input  logic              enable,
  output logic [HALF_W-1:0] half,
  output logic [BIT_W-1:0]  nbits,
  output logic [BIT_W-1:0]  nhigh
);
  localparam int NORM_DIV = 2 * NORM_BITS;
  logic [RATIO_W-1:0] ratio;

  always_comb begin
    if (act.usb) begin
      ratio = usb_ratio(act.rate);
      if (act.bclk_half && enable) begin
        nbits = BIT_W'(ratio >> 2);
        half  = HALF_W'(2);
      end else begin
        nbits = BIT_W'(ratio >> 1);
        half  = HALF_W'(1);
      end
    end else begin
      ratio = norm_ratio(act.rate);
      nbits = BIT_W'(NORM_BITS);
      half  = HALF_W'(32'(ratio) / NORM_DIV);
    end
    nhigh = BIT_W'((32'(nbits) + 1) >> 1);
  end
endmodule

// File: rtl/srg_frame_seq.sv
module srg_frame_seq
  import srg_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              enable,
  input  logic              div_mclk,
  input  logic [HALF_W-1:0] half,
  input  logic [BIT_W-1:0]  nbits,
  input  logic [BIT_W-1:0]  nhigh,
  output logic              lrclk,
  output logic              bclk,
  output logic              strobe,
  output logic              load,
  output logic              running
);
  logic              run_q, run_d, tck_q, tck_d, tick;
  logic              bclk_q, bclk_d, lr_q, lr_d, stb_q, stb_d;
  logic [HALF_W-1:0] ph_q, ph_d;
  logic [BIT_W-1:0]  bit_q, bit_d;

  assign tick = !div_mclk || tck_q;

  always_comb begin
    run_d  = run_q;
    ph_d   = ph_q;
    bit_d  = bit_q;
    bclk_d = bclk_q;
    lr_d   = lr_q;
    stb_d  = 1'b0;
    load   = 1'b0;
    tck_d  = div_mclk ? !tck_q : 1'b0;
    if (!enable) begin
      run_d  = 1'b0;
      ph_d   = '0;
      bit_d  = '0;
      bclk_d = 1'b0;
      lr_d   = 1'b0;
      tck_d  = 1'b0;
      load   = 1'b1;
    end else if (!run_q) begin
      load = 1'b1;
      if (tick) begin
        run_d  = 1'b1;
        ph_d   = '0;
        bit_d  = '0;
        bclk_d = 1'b0;
        lr_d   = 1'b1;
        stb_d  = 1'b1;
      end
    end else if (tick) begin
      if (ph_q == half - HALF_W'(1)) begin
        ph_d = '0;
        if (!bclk_q) begin
          bclk_d = 1'b1;
        end else begin
          bclk_d = 1'b0;
          if (bit_q == nbits - BIT_W'(1)) begin
            bit_d = '0;
            lr_d  = 1'b1;
            stb_d = 1'b1;
            load  = 1'b1;
          end else begin
            bit_d = bit_q + BIT_W'(1);
            lr_d  = (bit_q + BIT_W'(1)) < nhigh;
          end
        end
      end else begin
        ph_d = ph_q + HALF_W'(1);
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      run_q  <= 1'b0;
      tck_q  <= 1'b0;
      ph_q   <= '0;
      bit_q  <= '0;
      bclk_q <= 1'b0;
      lr_q   <= 1'b0;
      stb_q  <= 1'b0;
    end else begin
      run_q  <= run_d;
      tck_q  <= tck_d;
      ph_q   <= ph_d;
      bit_q  <= bit_d;
      bclk_q <= bclk_d;
      lr_q   <= lr_d;
      stb_q  <= stb_d;
    end
  end

  assign lrclk   = lr_q;
  assign bclk    = bclk_q;
  assign strobe  = stb_q;
  assign running = run_q;

  // R9
  strobe_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
    stb_q |-> (lr_q && !$past(lr_q)));
  // R8
  lr_edge_bclk_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (lr_q != $past(lr_q)) |-> !bclk_q);
  // R11
  idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !enable |=> (!lr_q && !bclk_q && !stb_q));
  // R7
  bit_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    run_q |-> (bit_q < nbits));
endmodule

// File: rtl/srg_clkgen.sv
module srg_clkgen
  import srg_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       wr_en,
  input  logic [7:0] wr_data,
  input  logic       enable,
  output logic       lrclk,
  output logic       bclk,
  output logic       frame_strobe
);
  logic              rs1_q, rs2_q, rst_sn;
  logic              load, running;
  ctl_t              act;
  logic [HALF_W-1:0] half;
  logic [BIT_W-1:0]  nbits, nhigh;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rs1_q <= 1'b0;
      rs2_q <= 1'b0;
    end else begin
      rs1_q <= 1'b1;
      rs2_q <= rs1_q;
    end
  end
  assign rst_sn = rs2_q;

  srg_ctl_regs u_regs (
    .clk(clk), .rst_n(rst_sn), .wr_en(wr_en), .wr_data(wr_data),
    .load(load), .act(act)
  );

  srg_rate_decode u_dec (
    .act(act), .enable(enable), .half(half), .nbits(nbits), .nhigh(nhigh)
  );

  srg_frame_seq u_seq (
    .clk(clk), .rst_n(rst_sn), .enable(enable), .div_mclk(act.mclk_half),
    .half(half), .nbits(nbits), .nhigh(nhigh), .lrclk(lrclk), .bclk(bclk),
    .strobe(frame_strobe), .load(load), .running(running)
  );

  // R10
  cfg_hold_chk: assert property (@(posedge clk) disable iff (!rst_sn)
    (running && $past(running) && !frame_strobe) |-> $stable(act));
endmodule

// File: tb/sim_srg_clkgen.sv
module sim_srg_clkgen;
  logic       clk, rst_n, wr_en, enable;
  logic [7:0] wr_data;
  logic       lrclk, bclk, frame_strobe;
  int         checks, errors;
  bit         done;

  srg_clkgen u0 (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_data(wr_data),
    .enable(enable), .lrclk(lrclk), .bclk(bclk), .frame_strobe(frame_strobe)
  );

  initial clk = 1'b0;
  always #10 clk = ~clk;

  task automatic chk(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual %0d expected %0d", tag, act, exp);
    end
  endtask

  function automatic void calc(input logic [7:0] c, output int fr, output int hi,
                               output int bp);
    int r, p, n, m;
    m = c[6] ? 2 : 1;
    if (c[0]) begin
      case (c[5:1])
        5'b10001: r = 272;
        5'b00110: r = 1496;
        default:  r = 250;
      endcase
      p = c[7] ? 4 : 2;
      n = r / p;
    end else begin
      case (c[5:1])
        5'd1:    r = 128;
        5'd2:    r = 384;
        5'd3:    r = 192;
        default: r = 256;
      endcase
      n = 32;
      p = r / 32;
    end
    fr = n * p * m;
    hi = ((n + 1) / 2) * p * m;
    bp = p * m;
  endfunction

  task automatic wait_strobe();
    int g = 0;
    do begin
      @(negedge clk);
      g++;
    end while (!frame_strobe && g < 8000);
  endtask

  task automatic measure(input bit do_wr, input logic [7:0] w,
                         output int fr, output int hi, output int bp);
    int r1, r2, badfall;
    logic pb, pl;
    fr = 0; hi = 0; r1 = -1; r2 = -1; badfall = 0;
    chk("R8 bclk low at frame start", int'(bclk), 0);
    chk("R9 lrclk high with strobe", int'(lrclk), 1);
    pb = bclk; pl = lrclk;
    forever begin
      fr++;
      if (lrclk) hi++;
      if (bclk && !pb) begin
        if (r1 < 0) r1 = fr; else if (r2 < 0) r2 = fr;
      end
      if (pl && !lrclk && bclk) badfall++;
      pb = bclk; pl = lrclk;
      if (do_wr && fr == 20) begin wr_en = 1'b1; wr_data = w; end
      if (do_wr && fr == 21) wr_en = 1'b0;
      @(negedge clk);
      if (frame_strobe || fr > 8000) break;
    end
    bp = r2 - r1;
    chk("R8 lrclk falls while bclk low", badfall, 0);
  endtask

  task automatic apply(input logic [7:0] c);
    wr_en = 1'b1; wr_data = c;
    @(negedge clk);
    wr_en = 1'b0;
    wait_strobe();
  endtask

  task automatic run_cfg(input string tag, input logic [7:0] c);
    int fr, hi, bp, efr, ehi, ebp;
    apply(c);
    calc(c, efr, ehi, ebp);
    measure(1'b0, 8'h00, fr, hi, bp);
    chk({tag, " frame"}, fr, efr);
    chk({tag, " lrclk high"}, hi, ehi);
    chk({tag, " bclk period"}, bp, ebp);
  endtask

  initial begin
    repeat (195000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    int fr, hi, bp, g;
    int unsigned seed;
    logic [7:0] c;
    checks = 0; errors = 0; done = 1'b0;
    rst_n = 1'b0; wr_en = 1'b0; wr_data = '0; enable = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    chk("R1 lrclk after reset", int'(lrclk), 0);
    chk("R1 bclk after reset", int'(bclk), 0);
    chk("R1 strobe after reset", int'(frame_strobe), 0);
    enable = 1'b1;
    wait_strobe();
    measure(1'b0, 8'h00, fr, hi, bp);
    chk("R1 reset setting frame 256", fr, 256);
    chk("R2 reset setting bclk period 8", bp, 8);

    run_cfg("R2 code 2 ratio 384", 8'b0_0_00010_0);
    run_cfg("R2 code 1 ratio 128", 8'b0_0_00001_0);
    run_cfg("R2 code 3 ratio 192", 8'b0_0_00011_0);
    run_cfg("R3 halved clk code 0", 8'b0_1_00000_0);
    run_cfg("R6 bclk halving ignored in standard mode", 8'b1_0_00000_0);
    run_cfg("R4 R7 usb 250 odd bit count", 8'b0_0_00000_1);
    run_cfg("R5 R7 usb 250 bclk halved", 8'b1_0_00000_1);
    run_cfg("R4 usb 272", 8'b0_0_10001_1);
    run_cfg("R5 usb 272 bclk halved", 8'b1_0_10001_1);
    run_cfg("R4 usb 1496", 8'b0_0_00110_1);

    run_cfg("R10 base", 8'b0_0_00000_0);
    measure(1'b1, 8'b0_0_00110_1, fr, hi, bp);
    chk("R10 frame in progress keeps old length", fr, 256);
    measure(1'b0, 8'h00, fr, hi, bp);
    chk("R10 next frame uses new setting", fr, 1496);

    enable = 1'b0;
    repeat (2) @(negedge clk);
    chk("R11 lrclk low when disabled", int'(lrclk), 0);
    chk("R11 bclk low when disabled", int'(bclk), 0);
    wr_en = 1'b1; wr_data = 8'b0_1_00000_0;
    @(negedge clk);
    wr_en = 1'b0;
    @(negedge clk);
    enable = 1'b1;
    g = 0;
    do begin @(negedge clk); g++; end while (!frame_strobe && g < 10);
    chk("R11 strobe soon after enable", int'(g <= 3), 1);
    measure(1'b0, 8'h00, fr, hi, bp);
    chk("R11 R3 first frame after enable", fr, 512);

    seed = 32'd1234;
    void'($urandom(seed));
    for (int i = 0; i < 12; i++) begin
      c = 8'($urandom);
      if (c[2:1] == 2'b11 && c[0]) c[5:1] = 5'b10001;
      if (c[6] && c[0] && c[5:1] == 5'b00110) c[6] = 1'b0;
      run_cfg("R2 R4 R5 R7 random setting", c);
    end

    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule